// File: doc/BRIEF.md
# Paged MMU Control and Fault Register File

This block is the software-visible register file of a paged memory management unit. It holds the translation control word, the root pointer of the context table, the active context number, and two pairs of fault registers. One pair captures synchronous translation faults and the other captures asynchronous bus errors. The walker reads the translation enable and the context number straight from dedicated outputs. When translation is disabled, the walker forwards virtual addresses to the bus unchanged.

The translation unit reports a fault on a single-cycle strobe. The report carries the table level, the access type, the fault type, external bus error bits, the faulting address, and a flag that says whether that address is meaningful. The block records the report and raises a one-cycle trap request toward the processor. A no-fault control bit keeps the recording but suppresses the trap. The exception is an access flagged as belonging to the always-trapping address space, which still traps.

If a second fault arrives before software has read the status, the status word marks itself as overwritten. Software uses a plain strobed read/write port.

Top module: `mmu_regfile`

## Requirements
- R1: After reset the control word reads as the implementation id in bits 31:28 and the version id in bits 27:24, with every other bit 0. Every other register reads 0, and `trap_o`, `xlat_en` and `ctx_num` are 0.
- R2: The control word sits at offset 0x000. A write stores the system field (bits 23:8), the store-ordering bit (bit 7), no-fault (bit 1) and enable (bit 0). Bits 31:24 keep their ids, and bits 6:2 read as 0. `xlat_en` follows bit 0 from the cycle after the write.
- R3: The context-table pointer sits at 0x100 and stores bits 31:2, with bits 1:0 reading 0. The context register sits at 0x200 and stores its low CTX_W bits. `ctx_num` shows the stored value from the cycle after the write.
- R4: A fault report is visible from the next cycle. The status word at 0x300 is laid out as follows: bits 31:18 are 0, bus error bits are in 17:10, the level is in 9:8 (0 = context table, 1 to 3 = table levels), the access type is in 7:5, the fault type is in 4:2, address-valid is in bit 1 and overwrite is in bit 0. The fault address at 0x400 holds the reported address.
- R5: With no-fault (control bit 1) at 0, each fault report produces `trap_o` high for exactly the one cycle after the report.
- R6: With no-fault at 1, a fault still updates both fault registers, but `trap_o` stays low. The exception is a report with `flt_force_trap` set, which still traps.
- R7: A fault that arrives after a previous fault, with no read of 0x300 in between, sets status bit 0. A fault after such a read leaves bit 0 clear.
- R8: A read of 0x300 returns the value held before the read. From the next cycle the overwrite bit and the fault type field read 0, and the other fields are unchanged.
- R9: An asynchronous bus error report loads the status at 0x500 as follows: uncorrectable in bit 12, timeout in bit 11, bus error in bit 10, physical address bits 35:32 in bits 7:4, and bit 0 set. The address at 0x600 holds physical address bits 31:0.
- R10: Writes to offsets 0x300 to 0x600 have no effect. Reads of any offset other than the seven listed return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_sel | input | 1 | Software access strobe |
| sw_we | input | 1 | 1 = write, 0 = read |
| sw_addr | input | 12 | Register byte offset |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data, valid in the strobe cycle |
| flt_valid | input | 1 | Fault report strobe |
| flt_level | input | 2 | Table level of the fault |
| flt_acc | input | 3 | Access type code |
| flt_type | input | 3 | Fault type code |
| flt_ebe | input | 8 | External bus error bits |
| flt_addr | input | 32 | Faulting virtual address |
| flt_addr_ok | input | 1 | Faulting address is meaningful |
| flt_force_trap | input | 1 | Access lies in the always-trapping space |
| abus_valid | input | 1 | Asynchronous bus error strobe |
| abus_uce | input | 1 | Uncorrectable error |
| abus_bto | input | 1 | Bus timeout |
| abus_berr | input | 1 | Generic bus error |
| abus_addr | input | 36 | Physical address of the error |
| trap_o | output | 1 | One-cycle trap request |
| xlat_en | output | 1 | Translation enable for the walker |
| ctx_num | output | 8 | Active context number |

## Verification
A stale unread flag shows up at 0x300 on the second fault after a read. It appears as an overwrite bit set or missing in the very next status read, so the random sequence interleaves reads with single and back-to-back faults. A wrong no-fault latch shows up on `trap_o` one clock after the next report. A wrong control or context register shows up on `xlat_en` or `ctx_num` one clock after the write, well before any read-back. The bench keeps a running model of every register and compares each read against it.

// File: rtl/mmu_reg_pkg.sv
package mmu_reg_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_CTP  = 3'd1,
    SEL_CTX  = 3'd2,
    SEL_FSR  = 3'd3,
    SEL_FAR  = 3'd4,
    SEL_AFSR = 3'd5,
    SEL_AFAR = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [15:0] sysf;
    logic        pso;
    logic        nofault;
    logic        enable;
  } ctrl_t;

  // Offsets are 0x000..0x600 in steps of 0x100; low byte must be zero.
  function automatic reg_sel_e decode_off(input logic [11:0] a);
    if (a[7:0] != 8'h00 || a[11] || a[10:8] == 3'd7) return SEL_NONE;
    return reg_sel_e'(a[10:8]);
  endfunction

  function automatic logic [31:0] ctrl_view(input logic [3:0] impl,
                                            input logic [3:0] vers,
                                            input ctrl_t c);
    return {impl, vers, c.sysf, c.pso, 5'b0, c.nofault, c.enable};
  endfunction

  function automatic ctrl_t ctrl_load(input logic [31:0] w);
    ctrl_t c;
    c.sysf    = w[23:8];
    c.pso     = w[7];
    c.nofault = w[1];
    c.enable  = w[0];
    return c;
  endfunction

  function automatic logic [31:0] fsr_pack(input logic [7:0] ebe,
                                           input logic [1:0] lvl,
                                           input logic [2:0] acc,
                                           input logic [2:0] ft,
                                           input logic       fav,
                                           input logic       ow);
    return {14'b0, ebe, lvl, acc, ft, fav, ow};
  endfunction

  // Clear overwrite and fault type after a software read.
  function automatic logic [31:0] fsr_after_read(input logic [31:0] f);
    return {f[31:5], 3'b000, f[1], 1'b0};
  endfunction

  function automatic logic [31:0] afsr_pack(input logic uce, input logic bto,
                                            input logic berr,
                                            input logic [3:0] hi);
    return {19'b0, uce, bto, berr, 2'b00, hi, 3'b000, 1'b1};
  endfunction

endpackage

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_reg_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_ctp,
  input  logic              wr_ctx,
  input  logic [31:0]       wdata,
  output ctrl_t             ctrl_q,
  output logic [29:0]       ctp_q,
  output logic [CTX_W-1:0]  ctx_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ctp_q  <= '0;
      ctx_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_load(wdata);
      if (wr_ctp)  ctp_q  <= wdata[31:2];
      if (wr_ctx)  ctx_q  <= wdata[CTX_W-1:0];
    end
  end

endmodule

// File: rtl/mmu_sync_fault.sv
module mmu_sync_fault
  import mmu_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flt_valid,
  input  logic [1:0]  flt_level,
  input  logic [2:0]  flt_acc,
  input  logic [2:0]  flt_type,
  input  logic [7:0]  flt_ebe,
  input  logic [31:0] flt_addr,
  input  logic        flt_addr_ok,
  input  logic        flt_force_trap,
  input  logic        nofault,
  input  logic        rd_fsr,
  output logic [31:0] fsr_q,
  output logic [31:0] far_q,
  output logic        unread_q,
  output logic        trap_q
);

  logic ow_next;
  logic trap_want;

  // Overwrite only if the previous record is still unread at this edge.
  assign ow_next   = unread_q && !rd_fsr;
  assign trap_want = flt_valid && (!nofault || flt_force_trap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q    <= '0;
      far_q    <= '0;
      unread_q <= 1'b0;
      trap_q   <= 1'b0;
    end else begin
      trap_q <= trap_want;
      if (flt_valid) begin
        fsr_q    <= fsr_pack(flt_ebe, flt_level, flt_acc, flt_type,
                             flt_addr_ok, ow_next);
        far_q    <= flt_addr;
        unread_q <= 1'b1;
      end else if (rd_fsr) begin
        fsr_q    <= fsr_after_read(fsr_q);
        unread_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mmu_async_fault.sv
module mmu_async_fault
  import mmu_reg_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abus_valid,
  input  logic            abus_uce,
  input  logic            abus_bto,
  input  logic            abus_berr,
  input  logic [PA_W-1:0] abus_addr,
  output logic [31:0]     afsr_q,
  output logic [31:0]     afar_q
);

  localparam int HI_W = PA_W - 32;

  logic [3:0] hi_bits;

  generate
    if (HI_W >= 4) begin : g_full
      assign hi_bits = abus_addr[35:32];
    end else if (HI_W > 0) begin : g_part
      assign hi_bits = {{(4-HI_W){1'b0}}, abus_addr[PA_W-1:32]};
    end else begin : g_none
      assign hi_bits = 4'h0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      afsr_q <= '0;
      afar_q <= '0;
    end else if (abus_valid) begin
      afsr_q <= afsr_pack(abus_uce, abus_bto, abus_berr, hi_bits);
      afar_q <= abus_addr[31:0];
    end
  end

endmodule

// File: rtl/mmu_regfile.sv
module mmu_regfile
  import mmu_reg_pkg::*;
#(
  parameter logic [3:0] IMPL_ID = 4'h3,
  parameter logic [3:0] VERS_ID = 4'h2,
  parameter int         CTX_W   = 8,
  parameter int         PA_W    = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_sel,
  input  logic             sw_we,
  input  logic [11:0]      sw_addr,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic             flt_valid,
  input  logic [1:0]       flt_level,
  input  logic [2:0]       flt_acc,
  input  logic [2:0]       flt_type,
  input  logic [7:0]       flt_ebe,
  input  logic [31:0]      flt_addr,
  input  logic             flt_addr_ok,
  input  logic             flt_force_trap,
  input  logic             abus_valid,
  input  logic             abus_uce,
  input  logic             abus_bto,
  input  logic             abus_berr,
  input  logic [PA_W-1:0]  abus_addr,
  output logic             trap_o,
  output logic             xlat_en,
  output logic [CTX_W-1:0] ctx_num
);

  reg_sel_e    sel;
  logic        wr_ctrl, wr_ctp, wr_ctx, rd_fsr, ctrl_wr_evt;
  ctrl_t       ctrl_q;
  logic [29:0] ctp_q;
  logic [CTX_W-1:0] ctx_q;
  logic [31:0] fsr_q, far_q, afsr_q, afar_q;
  logic        unread_q;
  logic        nofault_bit;

  assign sel         = decode_off(sw_addr);
  assign wr_ctrl     = sw_sel && sw_we && sel == SEL_CTRL;
  assign wr_ctp      = sw_sel && sw_we && sel == SEL_CTP;
  assign wr_ctx      = sw_sel && sw_we && sel == SEL_CTX;
  assign rd_fsr      = sw_sel && !sw_we && sel == SEL_FSR;
  assign ctrl_wr_evt = wr_ctrl;
  assign nofault_bit = ctrl_q.nofault;

  mmu_ctl_regs #(.CTX_W(CTX_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wr_ctp  (wr_ctp),
    .wr_ctx  (wr_ctx),
    .wdata   (sw_wdata),
    .ctrl_q  (ctrl_q),
    .ctp_q   (ctp_q),
    .ctx_q   (ctx_q)
  );

  mmu_sync_fault u_sync (
    .clk            (clk),
    .rst_n          (rst_n),
    .flt_valid      (flt_valid),
    .flt_level      (flt_level),
    .flt_acc        (flt_acc),
    .flt_type       (flt_type),
    .flt_ebe        (flt_ebe),
    .flt_addr       (flt_addr),
    .flt_addr_ok    (flt_addr_ok),
    .flt_force_trap (flt_force_trap),
    .nofault        (nofault_bit),
    .rd_fsr         (rd_fsr),
    .fsr_q          (fsr_q),
    .far_q          (far_q),
    .unread_q       (unread_q),
    .trap_q         (trap_o)
  );

  mmu_async_fault #(.PA_W(PA_W)) u_async (
    .clk        (clk),
    .rst_n      (rst_n),
    .abus_valid (abus_valid),
    .abus_uce   (abus_uce),
    .abus_bto   (abus_bto),
    .abus_berr  (abus_berr),
    .abus_addr  (abus_addr),
    .afsr_q     (afsr_q),
    .afar_q     (afar_q)
  );

  assign xlat_en = ctrl_q.enable;
  assign ctx_num = ctx_q;

  always_comb begin
    unique case (sel)
      SEL_CTRL: sw_rdata = ctrl_view(IMPL_ID, VERS_ID, ctrl_q);
      SEL_CTP:  sw_rdata = {ctp_q, 2'b00};
      SEL_CTX:  sw_rdata = 32'(ctx_q);
      SEL_FSR:  sw_rdata = fsr_q;
      SEL_FAR:  sw_rdata = far_q;
      SEL_AFSR: sw_rdata = afsr_q;
      SEL_AFAR: sw_rdata = afar_q;
      default:  sw_rdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/mmu_regfile_chk.sv
module mmu_regfile_chk #(
  parameter int CTX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flt_valid,
  input logic             flt_force_trap,
  input logic             abus_valid,
  input logic             rd_fsr,
  input logic             ctrl_wr_evt,
  input logic             nofault_bit,
  input logic             unread_q,
  input logic [31:0]      fsr_q,
  input logic             trap_o,
  input logic             xlat_en,
  input logic [31:0]      afsr_q
);

  // R4: reserved status bits never set
  always @(posedge clk)
    if (rst_n) assert_fsr_resv_zero_R4: assert (fsr_q[31:18] == 14'h0);

  // R5: no trap without a report in the preceding cycle
  assert_trap_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(flt_valid));

  // R5: trap follows a report when no-fault is clear
  assert_trap_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !nofault_bit) |=> trap_o);

  // R6: forced space traps regardless of no-fault
  assert_force_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_force_trap) |=> trap_o);

  // R7: second unread fault marks overwrite
  assert_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && unread_q && !rd_fsr) |=> fsr_q[0]);

  // R8: read clears overwrite and fault type
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fsr && !flt_valid) |=> (fsr_q[0] == 1'b0 && fsr_q[4:2] == 3'b000));

  // R2: enable moves only on a control write
  assert_enable_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_evt |=> $stable(xlat_en));

  // R9: async report marks occurrence
  assert_async_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abus_valid |=> afsr_q[0]);

endmodule

bind mmu_regfile mmu_regfile_chk #(.CTX_W(CTX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flt_valid      (flt_valid),
  .flt_force_trap (flt_force_trap),
  .abus_valid     (abus_valid),
  .rd_fsr         (rd_fsr),
  .ctrl_wr_evt    (ctrl_wr_evt),
  .nofault_bit    (nofault_bit),
  .unread_q       (unread_q),
  .fsr_q          (fsr_q),
  .trap_o         (trap_o),
  .xlat_en        (xlat_en),
  .afsr_q         (afsr_q)
);

// File: tb/sim_mmu_regfile.sv
`timescale 1ns/1ps
module sim_mmu_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_sel = 0, sw_we = 0;
  logic [11:0] sw_addr = 0;
  logic [31:0] sw_wdata = 0;
  logic [31:0] sw_rdata;
  logic        flt_valid = 0;
  logic [1:0]  flt_level = 0;
  logic [2:0]  flt_acc = 0, flt_type = 0;
  logic [7:0]  flt_ebe = 0;
  logic [31:0] flt_addr = 0;
  logic        flt_addr_ok = 0, flt_force_trap = 0;
  logic        abus_valid = 0, abus_uce = 0, abus_bto = 0, abus_berr = 0;
  logic [35:0] abus_addr = 0;
  logic        trap_o, xlat_en;
  logic [7:0]  ctx_num;

  int checks = 0;
  int fails  = 0;

  // running model
  logic [31:0] m_ctrl, m_ctp, m_ctx, m_fsr, m_far, m_afsr, m_afar;
  logic        m_unread, m_nf;

  always #2.5 clk = ~clk;

  mmu_regfile u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_fsr(input logic [7:0] e, input logic [1:0] l,
      input logic [2:0] a, input logic [2:0] t, input logic v, input logic o);
    return (32'(e) << 10) | (32'(l) << 8) | (32'(a) << 5) | (32'(t) << 2)
         | (32'(v) << 1) | 32'(o);
  endfunction

  task automatic sw_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_sel = 1; sw_we = 1; sw_addr = a; sw_wdata = d;
    @(negedge clk);
    sw_sel = 0; sw_we = 0;
    if (a == 12'h000) begin
      m_ctrl = (d & 32'h00FFFF83) | 32'h32000000;
      m_nf   = d[1];
    end else if (a == 12'h100) m_ctp = d & 32'hFFFFFFFC;
    else if (a == 12'h200) m_ctx = d & 32'hFF;
  endtask

  task automatic sw_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sw_sel = 1; sw_we = 0; sw_addr = a;
    #1 d = sw_rdata;
    @(negedge clk);
    sw_sel = 0;
  endtask

  task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    sw_read(a, d);
    check(req, d, exp);
    if (a == 12'h300) begin
      m_fsr    = m_fsr & ~32'h0000001D;
      m_unread = 0;
    end
  endtask

  task automatic fault(input logic [7:0] e, input logic [1:0] l, input logic [2:0] a,
      input logic [2:0] t, input logic [31:0] ad, input logic v, input logic frc);
    @(negedge clk);
    flt_valid = 1; flt_ebe = e; flt_level = l; flt_acc = a; flt_type = t;
    flt_addr = ad; flt_addr_ok = v; flt_force_trap = frc;
    @(negedge clk);
    flt_valid = 0;
    check((m_nf && !frc) ? "R6 trap suppress" : "R5 trap pulse",
          32'(trap_o), 32'(!m_nf || frc));
    m_fsr = exp_fsr(e, l, a, t, v, m_unread);
    m_far = ad;
    m_unread = 1;
    @(negedge clk);
    check("R5 trap one cycle", 32'(trap_o), 32'h0);
  endtask

  task automatic async_err(input logic u, input logic b, input logic r, input logic [35:0] ad);
    @(negedge clk);
    abus_valid = 1; abus_uce = u; abus_bto = b; abus_berr = r; abus_addr = ad;
    @(negedge clk);
    abus_valid = 0;
    m_afsr = (32'(u) << 12) | (32'(b) << 11) | (32'(r) << 10) | (32'(ad[35:32]) << 4) | 32'h1;
    m_afar = ad[31:0];
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    m_ctrl = 32'h32000000; m_ctp = 0; m_ctx = 0; m_fsr = 0; m_far = 0;
    m_afsr = 0; m_afar = 0; m_unread = 0; m_nf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 trap", 32'(trap_o), 0);
    check("R1 xlat_en", 32'(xlat_en), 0);
    check("R1 ctx_num", 32'(ctx_num), 0);
    read_check("R1 ctrl", 12'h000, 32'h32000000);
    for (int i = 1; i <= 6; i++) read_check("R1 regs", 12'(i << 8), 32'h0);

    // R2 control write
    sw_write(12'h000, 32'hFFFFFFFF);
    check("R2 xlat_en", 32'(xlat_en), 1);
    read_check("R2 ctrl", 12'h000, m_ctrl);
    sw_write(12'h000, 32'h00000000);
    check("R2 xlat_en off", 32'(xlat_en), 0);

    // R3 pointer and context
    sw_write(12'h100, 32'hDEADBEEF);
    read_check("R3 ctp", 12'h100, 32'hDEADBEEC);
    sw_write(12'h200, 32'h0000_01A5);
    check("R3 ctx_num", 32'(ctx_num), 32'hA5);
    read_check("R3 ctx", 12'h200, 32'hA5);

    // R4/R5 single fault, then R8 read and clear
    fault(8'h5A, 2'd3, 3'd7, 3'd4, 32'h1234_5678, 1'b1, 1'b0);
    read_check("R4 far", 12'h400, 32'h1234_5678);
    read_check("R8 fsr pre-clear", 12'h300, exp_fsr(8'h5A, 2'd3, 3'd7, 3'd4, 1, 0));
    read_check("R8 fsr cleared", 12'h300, exp_fsr(8'h5A, 2'd3, 3'd7, 3'd0, 1, 0));

    // R7 back-to-back faults without a read
    fault(8'h01, 2'd0, 3'd0, 3'd1, 32'h0000_1000, 1'b0, 1'b0);
    fault(8'h80, 2'd1, 3'd4, 3'd2, 32'h0000_2000, 1'b1, 1'b0);
    read_check("R7 overwrite set", 12'h300, exp_fsr(8'h80, 2'd1, 3'd4, 3'd2, 1, 1));
    fault(8'h00, 2'd2, 3'd1, 3'd3, 32'h0000_3000, 1'b1, 1'b0);
    read_check("R7 overwrite clear", 12'h300, exp_fsr(8'h00, 2'd2, 3'd1, 3'd3, 1, 0));

    // R6 no-fault mode
    sw_write(12'h000, 32'h00000002);
    fault(8'h00, 2'd1, 3'd2, 3'd5, 32'hCAFE_0000, 1'b1, 1'b0);
    read_check("R6 far updated", 12'h400, 32'hCAFE_0000);
    fault(8'h00, 2'd1, 3'd2, 3'd6, 32'hCAFE_0004, 1'b1, 1'b1);

    // R9 async errors
    async_err(1, 0, 1, 36'hA_8765_4321);
    read_check("R9 afsr", 12'h500, m_afsr);
    read_check("R9 afar", 12'h600, 32'h8765_4321);

    // R10 ignored writes and unmapped reads
    for (int i = 3; i <= 6; i++) sw_write(12'(i << 8), 32'hFFFFFFFF);
    read_check("R10 fsr kept", 12'h300, m_fsr);
    read_check("R10 far kept", 12'h400, m_far);
    read_check("R10 afsr kept", 12'h500, m_afsr);
    read_check("R10 afar kept", 12'h600, m_afar);
    read_check("R10 unmapped 0x700", 12'h700, 0);
    read_check("R10 unmapped 0x104", 12'h104, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned op = $urandom_range(0, 5);
      case (op)
        0, 1: fault(8'($urandom), 2'($urandom), 3'($urandom), 3'($urandom),
                    $urandom, 1'($urandom), 1'($urandom_range(0, 3) == 0));
        2: read_check("R8 random fsr", 12'h300, m_fsr);
        3: begin
          sw_write(12'h000, $urandom);
          check("R2 random xlat_en", 32'(xlat_en), m_ctrl & 32'h1);
        end
        4: begin
          async_err(1'($urandom), 1'($urandom), 1'($urandom), {4'($urandom), 32'($urandom)});
          read_check("R9 random afsr", 12'h500, m_afsr);
        end
        default: begin
          int unsigned r = $urandom_range(0, 6);
          logic [31:0] e;
          case (r)
            0: e = m_ctrl; 1: e = m_ctp; 2: e = m_ctx; 3: e = m_fsr;
            4: e = m_far; 5: e = m_afsr; default: e = m_afar;
          endcase
          read_check("R4 random read", 12'(r << 8), e);
        end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule